// File: doc/BRIEF.md
# Memory-to-Pixel Line Fetch Engine

This block replays image lines stored in a memory frame buffer as a pixel stream, so that the rest of the pipeline sees them as if a sensor receiver had produced them. Software programs a base address, a line pitch, the number of leading pixels to drop, the number of pixels to keep, the pixel width in bits and the number of lines. It then pulses an enable request. The engine works out how many 64-bit words each line occupies, in whole 32-byte units. It fetches those words with fixed 32-beat read bursts on a memory port that it shares with another consumer. It then unpacks the words into pixels and sends the kept pixels out on a valid/ready stream.

The enable is refused while any logical receive channel of the live receiver is still active. In frame-synchronised mode, the engine also waits until the physical interface reports that it is idle before it issues the first read. After the last pixel of the last line has been accepted, a one-cycle done pulse is given and the engine returns to idle.

Top module: `lineFetchEngine`

## Requirements
- R1: After reset, chanEn, rdReq, pixValid, done and cfgErr are all 0.
- R2: An enable request made while chanActive is 1 is refused: chanEn stays 0 and no read is requested.
- R3: An enable request is rejected when startAddr or lineOffset has a nonzero value in its low 5 bits (not 32-byte aligned), or when bitsPerPix is 0 or greater than 16. A rejected request sets cfgErr to 1, keeps chanEn at 0 and issues no reads. While cfgErr is 1, chanEn is 0. The next accepted enable clears cfgErr.
- R4: When frameSync is 1 at enable, no read is requested while phyActive is 1.
- R5: rdReq is asserted only in cycles where portSel is 1.
- R6: Line n starts at startAddr + n*lineOffset. Each line needs W = 4*ceil((skipPix+countPix)*bitsPerPix/256) words. It is fetched with ceil(W/32) requests, at the line address plus 256*b for burst b. Each request is answered by 32 beats on rspValid.
- R7: Pixels are unpacked from the words of a line in little-endian order. Pixel j occupies line bits [j*bitsPerPix +: bitsPerPix], where bit 0 is bit 0 of the first word. The first skipPix pixels are dropped. The next countPix pixels are output in order, zero-extended to 16 bits, and padding bits are discarded.
- R8: While pixValid is 1 and pixReady is 0, pixValid stays 1 and pixData keeps its value. No pixel is lost or repeated.
- R9: After the last pixel of the last of lineCount lines is accepted, done is 1 for exactly one cycle. chanEn is 0 from the next cycle on.
- R10: rdReq is a one-cycle strobe. No new request is made until all 32 beats of the previous one have been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enReq | input | 1 | Enable request strobe |
| frameSync | input | 1 | Wait for the physical interface to go idle before fetching |
| startAddr | input | 32 | Byte address of line 0 |
| lineOffset | input | 32 | Byte pitch between lines |
| skipPix | input | 12 | Leading pixels dropped per line |
| countPix | input | 12 | Pixels output per line |
| bitsPerPix | input | 5 | Pixel width, 1 to 16 |
| lineCount | input | 12 | Number of lines to replay |
| chanActive | input | 1 | Any logical receive channel enabled |
| phyActive | input | 1 | Physical receive interface still active |
| portSel | input | 1 | Shared read port assigned to this engine |
| rdReq | output | 1 | Burst read request strobe |
| rdAddr | output | 32 | Burst byte address |
| rspValid | input | 1 | Read beat valid |
| rspData | input | 64 | Read beat data |
| pixReady | input | 1 | Downstream accepts a pixel |
| pixValid | output | 1 | Pixel valid |
| pixData | output | 16 | Pixel value |
| chanEn | output | 1 | Read channel enabled |
| cfgErr | output | 1 | Last enable rejected for configuration |
| done | output | 1 | All lines emitted |

## Verification
The checker watches, on every cycle, the port-ownership rule for requests and the absence of a new request while beats are still owed. It also checks that output pixels are held under backpressure, that refused enables never raise the channel, that a configuration error excludes an enabled channel, and that the channel drops after done. Only the bench scenarios can show the fetch geometry and the pixel content. These include the per-line word count, the burst addresses across lines, a partial final burst, the skipped and kept pixels for widths that straddle word boundaries, and the wait for the physical interface. The bench compares every request address and every accepted pixel with its own queues, which it builds from the formulas.

// File: rtl/lineFetchPkg.sv
package lineFetchPkg;

  typedef enum logic [2:0] {
    S_IDLE, S_WAITPHY, S_LINE, S_REQ, S_RECV, S_UNPACK, S_FIN
  } fetchState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgLoad;
    logic lineStart;
    logic lineNext;
    logic burstIssue;
    logic beatTake;
    logic unpackEn;
  } fetchCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic lineEmpty;
    logic beatLast;
    logic drained;
    logic pixDone;
    logic outBusy;
  } fetchStat_t;

endpackage

// File: rtl/lineFetchData.sv
module lineFetchData
  import lineFetchPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PIX_W  = 16,
  parameter int CNT_W  = 12,
  parameter int BPP_W  = 5,
  parameter int BEATS  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchCmd_t         cmd,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] lineOffset,
  input  logic [CNT_W-1:0]  skipPix,
  input  logic [CNT_W-1:0]  countPix,
  input  logic [BPP_W-1:0]  bitsPerPix,
  input  logic [63:0]       rspData,
  input  logic              pixReady,
  output fetchStat_t        stat,
  output logic [ADDR_W-1:0] burstAddr,
  output logic              pixValid,
  output logic [PIX_W-1:0]  pixData
);
  localparam int TOT_W  = CNT_W + 1;
  localparam int BITS_W = TOT_W + BPP_W;
  localparam int IDX_W  = $clog2(BEATS);
  localparam int PTR_W  = IDX_W + 1;
  localparam int ACC_W  = 128;

  logic [TOT_W-1:0]  totIn, totR, pixIdx;
  logic [BITS_W-1:0] bitsIn, wordsIn, lineWordsR, wordsLeft;
  logic [CNT_W-1:0]  skipR;
  logic [BPP_W-1:0]  bppR;
  logic [ADDR_W-1:0] offR, lineAddr;
  logic [PTR_W-1:0]  burstValid, wordPtr, take;
  logic [IDX_W-1:0]  beatCnt;
  logic [ACC_W-1:0]  acc;
  logic [7:0]        fill;
  logic [63:0]       wordBuf [BEATS];
  logic [PIX_W:0]    maskHi;
  logic [PIX_W-1:0]  pixMask;
  logic              canStep, haveBits;

  assign totIn   = TOT_W'(skipPix) + TOT_W'(countPix);
  assign bitsIn  = BITS_W'(totIn) * BITS_W'(bitsPerPix);
  assign wordsIn = ((bitsIn + BITS_W'(255)) >> 8) << 2;
  assign take    = (wordsLeft > BITS_W'(BEATS)) ? PTR_W'(BEATS) : PTR_W'(wordsLeft);
  assign maskHi  = {(PIX_W+1){1'b1}} << bppR;
  assign pixMask = ~maskHi[PIX_W-1:0];
  assign canStep = !pixValid || pixReady;
  assign haveBits = fill >= 8'(bppR);

  assign stat.lineEmpty = (wordsLeft == '0);
  assign stat.beatLast  = (beatCnt == IDX_W'(BEATS - 1));
  assign stat.drained   = !haveBits && (wordPtr == burstValid);
  assign stat.pixDone   = (pixIdx == totR);
  assign stat.outBusy   = pixValid;

  always_ff @(posedge clk) begin
    if (cmd.beatTake) wordBuf[beatCnt] <= rspData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      totR <= '0; skipR <= '0; bppR <= '0; offR <= '0; lineAddr <= '0;
      lineWordsR <= '0; burstAddr <= '0; wordsLeft <= '0; pixIdx <= '0;
      acc <= '0; fill <= '0; burstValid <= '0; beatCnt <= '0; wordPtr <= '0;
      pixValid <= 1'b0; pixData <= '0;
    end else begin
      if (cmd.cfgLoad) begin
        skipR <= skipPix; totR <= totIn; bppR <= bitsPerPix;
        offR <= lineOffset; lineAddr <= startAddr; lineWordsR <= wordsIn;
      end
      if (cmd.lineStart) begin
        burstAddr <= lineAddr; wordsLeft <= lineWordsR;
        pixIdx <= '0; acc <= '0; fill <= '0;
      end
      if (cmd.lineNext) lineAddr <= lineAddr + offR;
      if (cmd.burstIssue) begin
        burstValid <= take;
        wordsLeft  <= wordsLeft - BITS_W'(take);
        beatCnt    <= '0;
        wordPtr    <= '0;
        burstAddr  <= burstAddr + ADDR_W'(BEATS * 8);
      end
      if (cmd.beatTake) beatCnt <= beatCnt + 1'b1;
      if (pixValid && pixReady) pixValid <= 1'b0;
      if (cmd.unpackEn && canStep) begin
        if (haveBits && !stat.pixDone) begin
          acc    <= acc >> bppR;
          fill   <= fill - 8'(bppR);
          pixIdx <= pixIdx + 1'b1;
          if (pixIdx >= TOT_W'(skipR)) begin
            pixValid <= 1'b1;
            pixData  <= acc[PIX_W-1:0] & pixMask;
          end
        end else if (!haveBits && wordPtr < burstValid) begin
          acc     <= acc | (ACC_W'(wordBuf[wordPtr[IDX_W-1:0]]) << fill);
          fill    <= fill + 8'd64;
          wordPtr <= wordPtr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lineFetchCtrl.sv
module lineFetchCtrl
  import lineFetchPkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enReq,
  input  logic              frameSync,
  input  logic              cfgBad,
  input  logic [LINE_W-1:0] lineCount,
  input  logic              chanActive,
  input  logic              phyActive,
  input  logic              portSel,
  input  logic              rspValid,
  input  fetchStat_t        stat,
  output fetchCmd_t         cmd,
  output logic              rdReq,
  output logic              chanEn,
  output logic              cfgErr,
  output logic              done
);
  fetchState_t state, nxt;
  logic [LINE_W-1:0] linesR, lineIdx;
  logic accept;

  assign accept = (state == S_IDLE) && enReq && !chanActive && !cfgBad;
  assign rdReq  = (state == S_REQ) && portSel && !stat.lineEmpty;
  assign chanEn = (state != S_IDLE);
  assign done   = (state == S_FIN);

  always_comb begin
    nxt = state;
    cmd = '0;
    unique case (state)
      S_IDLE: if (accept) begin
        cmd.cfgLoad = 1'b1;
        nxt = frameSync ? S_WAITPHY : S_LINE;
      end
      S_WAITPHY: if (!phyActive) nxt = S_LINE;
      S_LINE: begin
        if (lineIdx == linesR) nxt = S_FIN;
        else begin
          cmd.lineStart = 1'b1;
          nxt = S_REQ;
        end
      end
      S_REQ: begin
        if (stat.lineEmpty) nxt = S_UNPACK;
        else if (portSel) begin
          cmd.burstIssue = 1'b1;
          nxt = S_RECV;
        end
      end
      S_RECV: begin
        cmd.beatTake = rspValid;
        if (rspValid && stat.beatLast) nxt = S_UNPACK;
      end
      S_UNPACK: begin
        cmd.unpackEn = 1'b1;
        if (stat.pixDone && !stat.outBusy) begin
          cmd.lineNext = 1'b1;
          nxt = S_LINE;
        end else if (!stat.pixDone && stat.drained) nxt = S_REQ;
      end
      S_FIN: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; linesR <= '0; lineIdx <= '0; cfgErr <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && enReq && !chanActive) cfgErr <= cfgBad;
      if (cmd.cfgLoad) begin
        linesR  <= lineCount;
        lineIdx <= '0;
      end
      if (cmd.lineNext) lineIdx <= lineIdx + 1'b1;
    end
  end
endmodule

// File: rtl/lineFetchEngine.sv
module lineFetchEngine
  import lineFetchPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PIX_W      = 16,
  parameter int CNT_W      = 12,
  parameter int LINE_W     = 12,
  parameter int BEATS      = 32,
  parameter int ALIGN_BITS = 5,
  localparam int BPP_W     = $clog2(PIX_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enReq,
  input  logic              frameSync,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] lineOffset,
  input  logic [CNT_W-1:0]  skipPix,
  input  logic [CNT_W-1:0]  countPix,
  input  logic [BPP_W-1:0]  bitsPerPix,
  input  logic [LINE_W-1:0] lineCount,
  input  logic              chanActive,
  input  logic              phyActive,
  input  logic              portSel,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rspValid,
  input  logic [63:0]       rspData,
  input  logic              pixReady,
  output logic              pixValid,
  output logic [PIX_W-1:0]  pixData,
  output logic              chanEn,
  output logic              cfgErr,
  output logic              done
);
  fetchCmd_t  cmd;
  fetchStat_t stat;
  logic cfgBad;

  assign cfgBad = (startAddr[ALIGN_BITS-1:0] != '0) || (lineOffset[ALIGN_BITS-1:0] != '0) ||
                  (bitsPerPix == '0) || (bitsPerPix > BPP_W'(PIX_W));

  lineFetchCtrl #(.LINE_W(LINE_W)) ctrl (
    .clk(clk), .rstN(rstN), .enReq(enReq), .frameSync(frameSync), .cfgBad(cfgBad),
    .lineCount(lineCount), .chanActive(chanActive), .phyActive(phyActive),
    .portSel(portSel), .rspValid(rspValid), .stat(stat), .cmd(cmd), .rdReq(rdReq),
    .chanEn(chanEn), .cfgErr(cfgErr), .done(done)
  );

  lineFetchData #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .CNT_W(CNT_W), .BPP_W(BPP_W),
                  .BEATS(BEATS)) dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .startAddr(startAddr), .lineOffset(lineOffset),
    .skipPix(skipPix), .countPix(countPix), .bitsPerPix(bitsPerPix), .rspData(rspData),
    .pixReady(pixReady), .stat(stat), .burstAddr(rdAddr), .pixValid(pixValid),
    .pixData(pixData)
  );
endmodule

// File: rtl/lineFetchChecker.sv
module lineFetchChecker #(
  parameter int PIX_W = 16,
  parameter int BEATS = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             enReq,
  input logic             chanActive,
  input logic             chanEn,
  input logic             cfgErr,
  input logic             portSel,
  input logic             rdReq,
  input logic             rspValid,
  input logic             pixValid,
  input logic             pixReady,
  input logic [PIX_W-1:0] pixData,
  input logic             done
);
  localparam int OW = $clog2(BEATS) + 1;
  logic [OW-1:0] owed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) owed <= '0;
    else if (rdReq) owed <= OW'(BEATS);
    else if (rspValid && owed != '0) owed <= owed - 1'b1;
  end

  a_r5_req_needs_port: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> portSel);
  a_r10_no_req_while_owed: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> owed == '0);
  a_r10_req_strobe: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);
  a_r8_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixReady) |=> (pixValid && $stable(pixData)));
  a_r2_refused_stays_off: assert property (@(posedge clk) disable iff (!rstN)
    (!chanEn && (chanActive || !enReq)) |=> !chanEn);
  a_r3_error_means_off: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !chanEn);
  a_r9_off_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!chanEn && !done));
endmodule

bind lineFetchEngine lineFetchChecker #(.PIX_W(PIX_W), .BEATS(BEATS)) chk (
  .clk(clk), .rstN(rstN), .enReq(enReq), .chanActive(chanActive), .chanEn(chanEn),
  .cfgErr(cfgErr), .portSel(portSel), .rdReq(rdReq), .rspValid(rspValid),
  .pixValid(pixValid), .pixReady(pixReady), .pixData(pixData), .done(done)
);

// File: tb/lineFetchEngine_test.sv
`timescale 1ns/1ps
module lineFetchEngine_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic enReq = 0, frameSync = 0, chanActive = 0, phyActive = 0, portSel = 1;
  logic [31:0] startAddr = 0, lineOffset = 0;
  logic [11:0] skipPix = 0, countPix = 0, lineCount = 0;
  logic [4:0]  bitsPerPix = 8;
  logic rdReq, rspValid = 0, pixReady = 1, pixValid, chanEn, cfgErr, done;
  logic [31:0] rdAddr;
  logic [63:0] rspData = 0;
  logic [15:0] pixData;

  int checks = 0, fails = 0, cyc = 0;
  int reqSeen = 0, reqWhilePhy = 0, doneCnt = 0;
  bit stress = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] expPix[$];
  logic [31:0] expAddr[$];
  logic prevStall = 0;
  logic [15:0] prevData = 0;

  always #2 clk = ~clk;

  lineFetchEngine uut (
    .clk(clk), .rstN(rstN), .enReq(enReq), .frameSync(frameSync), .startAddr(startAddr),
    .lineOffset(lineOffset), .skipPix(skipPix), .countPix(countPix),
    .bitsPerPix(bitsPerPix), .lineCount(lineCount), .chanActive(chanActive),
    .phyActive(phyActive), .portSel(portSel), .rdReq(rdReq), .rdAddr(rdAddr),
    .rspValid(rspValid), .rspData(rspData), .pixReady(pixReady), .pixValid(pixValid),
    .pixData(pixData), .chanEn(chanEn), .cfgErr(cfgErr), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] memWord(input logic [31:0] a);
    return {a ^ 32'h5A5A_1234, a * 32'h0001_0DCD + 32'h77};
  endfunction

  function automatic logic [15:0] pixAt(input logic [31:0] base, input int j, input int bpp);
    int bit0 = j * bpp;
    logic [31:0] w = 32'(bit0 / 64);
    logic [127:0] two = {memWord(base + 8 * (w + 1)), memWord(base + 8 * w)};
    logic [127:0] sh = two >> (bit0 % 64);
    logic [16:0] m = 17'h1FFFF << bpp;
    return sh[15:0] & ~m[15:0];
  endfunction

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R9 watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // stimulus for ready and port selection
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pixReady = stress ? (lfsr[0] | lfsr[3]) : 1'b1;
    portSel  = stress ? (lfsr[5] | lfsr[9]) : 1'b1;
  end

  // memory responder: 32 beats per request
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && rdReq) begin
        logic [31:0] a;
        a = rdAddr;
        @(posedge clk); #1;
        @(posedge clk); #1;
        for (int k = 0; k < 32; k++) begin
          rspValid = 1; rspData = memWord(a + 32'(8 * k));
          @(posedge clk); #1;
        end
        rspValid = 0;
      end
    end
  end

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall)
        chk(pixValid && pixData == prevData, "R8 hold under backpressure",
            {pixValid, pixData}, {1'b1, prevData});
      prevStall = pixValid && !pixReady;
      prevData  = pixData;
      if (pixValid && pixReady) begin
        if (expPix.size() == 0) chk(0, "R7 unexpected pixel", pixData, 0);
        else begin
          logic [15:0] e;
          e = expPix.pop_front();
          chk(pixData == e, "R7 pixel value", pixData, e);
        end
      end
      if (rdReq) begin
        reqSeen++;
        chk(portSel, "R5 request without port", portSel, 1);
        if (frameSync && phyActive) reqWhilePhy++;
        if (expAddr.size() == 0) chk(0, "R6 unexpected request", rdAddr, 0);
        else begin
          logic [31:0] ea;
          ea = expAddr.pop_front();
          chk(rdAddr == ea, "R6 burst address", rdAddr, ea);
        end
      end
      if (done) doneCnt++;
    end
  end

  task automatic pulseEnable();
    @(posedge clk); #1 enReq = 1;
    @(posedge clk); #1 enReq = 0;
  endtask

  task automatic runJob(input logic [31:0] sa, input logic [31:0] off, input int skip,
                        input int cnt, input int bpp, input int lines, input bit sync,
                        input int phyHold, input bit str);
    int words, nb, guard, req0;
    startAddr = sa; lineOffset = off; skipPix = 12'(skip); countPix = 12'(cnt);
    bitsPerPix = 5'(bpp); lineCount = 12'(lines); frameSync = sync;
    words = 4 * (((skip + cnt) * bpp + 255) / 256);
    nb = (words + 31) / 32;
    for (int n = 0; n < lines; n++) begin
      logic [31:0] base;
      base = sa + 32'(n) * off;
      for (int b = 0; b < nb; b++) expAddr.push_back(base + 32'(256 * b));
      for (int j = skip; j < skip + cnt; j++) expPix.push_back(pixAt(base, j, bpp));
    end
    doneCnt = 0; reqWhilePhy = 0; stress = str;
    phyActive = sync;
    req0 = reqSeen;
    pulseEnable();
    if (sync) begin
      repeat (phyHold) @(posedge clk);
      @(negedge clk);
      chk(reqSeen == req0, "R4 no request while physical interface active", reqSeen - req0, 0);
      #1 phyActive = 0;
    end
    @(negedge clk);
    chk(cfgErr == 0, "R3 accepted enable clears error", cfgErr, 0);
    guard = 0;
    while (doneCnt == 0 && guard < 40000) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk(chanEn == 0, "R9 channel off after done", chanEn, 0);
    repeat (3) @(negedge clk);
    chk(doneCnt == 1, "R9 single done pulse", doneCnt, 1);
    chk(expPix.size() == 0, "R7 all pixels emitted", expPix.size(), 0);
    chk(expAddr.size() == 0, "R6 all bursts issued", expAddr.size(), 0);
    if (sync) chk(reqWhilePhy == 0, "R4 requests during active interface", reqWhilePhy, 0);
    stress = 0;
    expPix.delete(); expAddr.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!chanEn && !rdReq && !pixValid && !done && !cfgErr, "R1 reset state",
        {chanEn, rdReq, pixValid, done, cfgErr}, 0);
    #1 rstN = 1;
    @(negedge clk);
    chk(!chanEn && !rdReq && !pixValid && !done && !cfgErr, "R1 idle after reset",
        {chanEn, rdReq, pixValid, done, cfgErr}, 0);

    // R2: refused while a logical channel is active
    startAddr = 32'h1000; lineOffset = 32'h100; skipPix = 0; countPix = 8;
    bitsPerPix = 8; lineCount = 1; chanActive = 1;
    pulseEnable();
    repeat (10) @(negedge clk);
    chk(chanEn == 0, "R2 enable refused", chanEn, 0);
    chk(reqSeen == 0, "R2 no read after refusal", reqSeen, 0);
    chanActive = 0;

    // R3: misaligned start, misaligned offset, bad width
    startAddr = 32'h1004;
    pulseEnable(); repeat (3) @(negedge clk);
    chk(cfgErr == 1 && chanEn == 0, "R3 misaligned start", {cfgErr, chanEn}, 2'b10);
    startAddr = 32'h1000; lineOffset = 32'h110;
    pulseEnable(); repeat (3) @(negedge clk);
    chk(cfgErr == 1 && chanEn == 0, "R3 misaligned offset", {cfgErr, chanEn}, 2'b10);
    lineOffset = 32'h100; bitsPerPix = 0;
    pulseEnable(); repeat (3) @(negedge clk);
    chk(cfgErr == 1 && chanEn == 0, "R3 zero pixel width", {cfgErr, chanEn}, 2'b10);
    bitsPerPix = 17;
    pulseEnable(); repeat (3) @(negedge clk);
    chk(cfgErr == 1 && chanEn == 0, "R3 pixel width too large", {cfgErr, chanEn}, 2'b10);
    repeat (20) @(negedge clk);
    chk(reqSeen == 0, "R3 no read after rejection", reqSeen, 0);

    // R6 R7: byte pixels, one burst per line
    runJob(32'h1000, 32'h100, 3, 20, 8, 2, 0, 0, 0);
    // R4 R7 R8 R10: straddling 10-bit pixels, four bursts per line, backpressure
    runJob(32'h20000, 32'h1020, 5, 700, 10, 2, 1, 25, 1);
    // R6: partial final burst with 7-bit pixels
    runJob(32'h8000, 32'h400, 1, 300, 7, 1, 0, 0, 0);
    // R7: single kept pixel, 12-bit, three lines under stress
    runJob(32'h400, 32'h40, 0, 1, 12, 3, 0, 0, 1);
    // R7: full-width pixels after a long skip
    runJob(32'h3000, 32'h0, 60, 4, 16, 1, 0, 0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule